// File: doc/BRIEF.md
# Test Output Selector with Bypass Dividers

This block produces the main output clock and a single-ended test output for a clock synthesiser. A 3-bit test code picks one of eight views for the test pin:
- a configuration shift-register bit;
- a constant high or a constant low;
- the reference clock;
- a pulse from an M counter;
- the output clock itself;
- the output clock divided by four.

The output clock comes from an N divider. Its divide ratio is 2, 4, 8 or 16, chosen by a 2-bit code.

The divider source is normally the VCO clock. One test code selects a bypass mode. In that mode, an external serial clock drives both the N divider and the M counter. This allows slow board-level functional tests without the PLL running. The analog loop and the configuration registers live outside this block. The VCO is seen only as an input clock.

All three source clocks are oversampled by the block clock. Each divider advances once per detected rising edge of its selected source, so every output is a register in the block clock domain.

Top module: `tsel_top`

## Requirements
- R1: While `rstN` is low, `foutOut` and `testOut` are both 0, and all divider state is cleared.
- R2: With test code 3'b000, `testOut` follows `lastBit` and settles within 3 block clock cycles of a change.
- R3: Test code 3'b001 holds `testOut` at 1, and test code 3'b101 holds it at 0, one cycle after the code is applied.
- R4: With test code 3'b010, `testOut` follows the level of `refClk` and settles within 3 block clock cycles of a change.
- R5: `foutOut` toggles after every 2^`nCode` source rising edges, counted from reset. Its period is therefore 2^(`nCode`+1) source edges with 50% duty: `nCode` 0 divides by 2, 1 by 4, 2 by 8 and 3 by 16. Its first rise follows the 2^`nCode`-th source edge.
- R6: With test code 3'b110 (bypass), the divider source is `serClk` and edges on `vcoClk` have no effect on either output. With every other code, the source is `vcoClk` and `serClk` edges have no effect.
- R7: With test code 3'b011 (VCO source) or 3'b110 (serial source), `testOut` is high for exactly one source period, starting at every `mMod`-th source rising edge after reset, and low otherwise (`mMod` >= 2).
- R8: With test code 3'b100, `testOut` carries the same level as `foutOut` once both have settled.
- R9: With test code 3'b111, `testOut` is the output clock divided by four. It rises at the 2nd and falls at the 4th rising edge of `foutOut`, and this pattern repeats every four output periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; oversamples all source clocks |
| rstN | input | 1 | Asynchronous active-low reset |
| testCode | input | 3 | Test view / mode select |
| refClk | input | 1 | Reference clock |
| vcoClk | input | 1 | VCO clock (normal divider source) |
| serClk | input | 1 | External serial clock (bypass divider source) |
| lastBit | input | 1 | Last bit of the configuration shift register |
| mMod | input | 9 | M counter modulus |
| nCode | input | 2 | N divide code: ratio 2^(nCode+1) |
| foutOut | output | 1 | Divided output clock |
| testOut | output | 1 | Test output |

## Verification
A source rising edge is synchronised on the first block clock edge and detected in that cycle. The dividers and the M pulse update on the second edge. The divide-by-four view updates on the third edge, and the registered test pin follows one edge after its selected view: up to four edges for the divide-by-four view. The bench therefore makes every source edge last five block cycles: two high and three low. It samples both outputs on the falling block clock edge at the end of that window, so each expected value is compared only after its whole register chain has settled. Static views (shift-register bit, reference level, constants) are sampled three falling edges after the input change. This leaves one cycle of margin over their two-register path.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  typedef enum logic [2:0] {
    VIEW_SHIFT  = 3'b000,
    VIEW_HIGH   = 3'b001,
    VIEW_REF    = 3'b010,
    VIEW_MPULSE = 3'b011,
    VIEW_FOUT   = 3'b100,
    VIEW_LOW    = 3'b101,
    VIEW_BYPASS = 3'b110,
    VIEW_FDIV4  = 3'b111
  } view_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  tick;      // one-cycle: selected source rose
    logic  refLevel;  // synchronised reference level
    view_e view;      // decoded test view
  } strobe_t;

endpackage

// File: rtl/tsel_ctrl.sv
module tsel_ctrl
  import tsel_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    testCode,
  input  logic          refClk,
  input  logic          vcoClk,
  input  logic          serClk,
  output strobe_t       strobe
);

  localparam int NumSrc = 3;
  localparam int IdxVco = 0;
  localparam int IdxSer = 1;
  localparam int IdxRef = 2;

  logic [NumSrc-1:0] rawIn;
  logic [NumSrc-1:0] syncQ;
  logic [NumSrc-1:0] prevQ;
  logic [NumSrc-1:0] riseQ;
  logic              bypassMode;

  assign rawIn = {refClk, serClk, vcoClk};

  generate
    for (genvar g = 0; g < NumSrc; g++) begin : gSample
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncQ[g] <= 1'b0;
          prevQ[g] <= 1'b0;
        end else begin
          syncQ[g] <= rawIn[g];
          prevQ[g] <= syncQ[g];
        end
      end
      assign riseQ[g] = syncQ[g] & ~prevQ[g];
    end
  endgenerate

  assign bypassMode = (testCode == VIEW_BYPASS);

  always_comb begin
    strobe.tick     = bypassMode ? riseQ[IdxSer] : riseQ[IdxVco];
    strobe.refLevel = syncQ[IdxRef];
    strobe.view     = view_e'(testCode);
  end

  // R6: in bypass, a tick needs a serial-clock edge seen across the sampling pair
  assert_bypass_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (bypassMode && strobe.tick) |-> (syncQ[IdxSer] && !prevQ[IdxSer]));

  // R6: outside bypass, the serial clock never produces a tick on its own
  assert_vco_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!bypassMode && !syncQ[IdxVco]) |-> !strobe.tick);

endmodule

// File: rtl/tsel_datapath.sv
module tsel_datapath
  import tsel_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_CODE_WIDTH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic                    lastBit,
  input  logic [M_WIDTH-1:0]      mMod,
  input  logic [N_CODE_WIDTH-1:0] nCode,
  output logic                    foutOut,
  output logic                    testOut
);

  localparam int HalfW = 2 ** N_CODE_WIDTH;
  localparam int Div4W = 2;

  logic [HalfW-1:0]   nCnt;
  logic [HalfW-1:0]   halfLimit;
  logic               foutQ;
  logic [M_WIDTH-1:0] mCnt;
  logic [M_WIDTH-1:0] mLimit;
  logic               mPulse;
  logic               foutPrev;
  logic               foutRise;
  logic [Div4W-1:0]   riseCnt;
  logic               div4Q;
  logic               testNext;

  // N divider: toggles every 2^nCode ticks
  assign halfLimit = (HalfW'(1) << nCode) - HalfW'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nCnt  <= '0;
      foutQ <= 1'b0;
    end else if (strobe.tick) begin
      if (nCnt >= halfLimit) begin
        nCnt  <= '0;
        foutQ <= ~foutQ;
      end else begin
        nCnt <= nCnt + HalfW'(1);
      end
    end
  end

  // M counter: pulse lasting one source period, every mMod ticks
  assign mLimit = mMod - M_WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt   <= '0;
      mPulse <= 1'b0;
    end else if (strobe.tick) begin
      if (mCnt >= mLimit) begin
        mCnt   <= '0;
        mPulse <= 1'b1;
      end else begin
        mCnt   <= mCnt + M_WIDTH'(1);
        mPulse <= 1'b0;
      end
    end
  end

  // Output clock divided by four: bit 1 of a count of its rising edges
  assign foutRise = foutQ & ~foutPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foutPrev <= 1'b0;
      riseCnt  <= '0;
    end else begin
      foutPrev <= foutQ;
      if (foutRise) riseCnt <= riseCnt + Div4W'(1);
    end
  end

  assign div4Q = riseCnt[Div4W-1];

  // Test view selection
  always_comb begin
    unique case (strobe.view)
      VIEW_SHIFT:  testNext = lastBit;
      VIEW_HIGH:   testNext = 1'b1;
      VIEW_REF:    testNext = strobe.refLevel;
      VIEW_MPULSE: testNext = mPulse;
      VIEW_FOUT:   testNext = foutQ;
      VIEW_LOW:    testNext = 1'b0;
      VIEW_BYPASS: testNext = mPulse;
      VIEW_FDIV4:  testNext = div4Q;
      default:     testNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) testOut <= 1'b0;
    else       testOut <= testNext;
  end

  assign foutOut = foutQ;

  // R5: the output clock only moves on a source tick
  assert_fout_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(foutQ));

  // R7: an M pulse only starts on a source tick
  assert_mpulse_on_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mPulse) |-> $past(strobe.tick));

  // R9: the divided view changes only after an output-clock rise
  assert_div4_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(div4Q) |-> $past(foutRise));

  // R3: constant views
  assert_const_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.view == VIEW_HIGH) |=> testOut);

  assert_const_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.view == VIEW_LOW) |=> !testOut);

endmodule

// File: rtl/tsel_top.sv
module tsel_top
  import tsel_pkg::*;
#(
  parameter int M_WIDTH = 9,
  parameter int N_CODE_WIDTH = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              testCode,
  input  logic                    refClk,
  input  logic                    vcoClk,
  input  logic                    serClk,
  input  logic                    lastBit,
  input  logic [M_WIDTH-1:0]      mMod,
  input  logic [N_CODE_WIDTH-1:0] nCode,
  output logic                    foutOut,
  output logic                    testOut
);

  strobe_t strobe;

  tsel_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .testCode (testCode),
    .refClk   (refClk),
    .vcoClk   (vcoClk),
    .serClk   (serClk),
    .strobe   (strobe)
  );

  tsel_datapath #(
    .M_WIDTH      (M_WIDTH),
    .N_CODE_WIDTH (N_CODE_WIDTH)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .lastBit (lastBit),
    .mMod    (mMod),
    .nCode   (nCode),
    .foutOut (foutOut),
    .testOut (testOut)
  );

  // R1: outputs leave reset low
  assert_reset_low_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (!foutOut && !testOut));

endmodule

// File: tb/tsel_top_tb_top.sv
`timescale 1ns/1ps
module tsel_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] testCode = 3'b000;
  logic       refClk = 1'b0;
  logic       vcoClk = 1'b0;
  logic       serClk = 1'b0;
  logic       lastBit = 1'b0;
  logic [8:0] mMod = 9'd4;
  logic [1:0] nCode = 2'd0;
  logic       foutOut;
  logic       testOut;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tsel_top dut_i (
    .clk(clk), .rstN(rstN), .testCode(testCode), .refClk(refClk),
    .vcoClk(vcoClk), .serClk(serClk), .lastBit(lastBit), .mMod(mMod),
    .nCode(nCode), .foutOut(foutOut), .testOut(testOut)
  );

  task automatic check(input string req, input logic actual, input logic expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s: actual %0b expected %0b (time %0t)", req, actual, expected, $time);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic applyReset(input logic [2:0] code, input logic [1:0] n, input logic [8:0] m);
    @(negedge clk);
    rstN = 1'b0; testCode = code; nCode = n; mMod = m;
    vcoClk = 1'b0; serClk = 1'b0; refClk = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
    waitNeg(1);
  endtask

  // One source edge: 2 cycles high, 3 cycles low; returns at settled point
  task automatic pulseSrc(input bit useSer);
    if (useSer) serClk = 1'b1; else vcoClk = 1'b1;
    waitNeg(2);
    if (useSer) serClk = 1'b0; else vcoClk = 1'b0;
    waitNeg(3);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0; testCode = 3'b001; lastBit = 1'b1; refClk = 1'b1;
    vcoClk = 1'b1; serClk = 1'b1;
    waitNeg(3);
    check("R1 fout in reset", foutOut, 1'b0);
    check("R1 test in reset", testOut, 1'b0);
    vcoClk = 1'b0; serClk = 1'b0; refClk = 1'b0;
  endtask

  task automatic testStatic();
    applyReset(3'b000, 2'd0, 9'd4);
    for (int i = 0; i < 4; i++) begin
      lastBit = i[0];
      waitNeg(3);
      check("R2 shift bit view", testOut, i[0]);
    end
    testCode = 3'b001; waitNeg(3);
    check("R3 constant high", testOut, 1'b1);
    testCode = 3'b101; waitNeg(3);
    check("R3 constant low", testOut, 1'b0);
    testCode = 3'b001; waitNeg(3);
    check("R3 constant high again", testOut, 1'b1);
  endtask

  task automatic testRef();
    applyReset(3'b010, 2'd0, 9'd4);
    for (int i = 1; i < 5; i++) begin
      refClk = i[0];
      waitNeg(3);
      check("R4 reference view", testOut, i[0]);
    end
  endtask

  task automatic testDivider(input logic [1:0] n);
    int half;
    half = 1 << n;
    applyReset(3'b100, n, 9'd4);
    for (int i = 1; i <= 4 * half; i++) begin
      pulseSrc(1'b0);
      check("R5 fout divide", foutOut, 1'(((i / half) % 2)));
      check("R8 fout on test", testOut, 1'(((i / half) % 2)));
    end
  endtask

  task automatic testSourceSelect();
    logic held;
    applyReset(3'b100, 2'd0, 9'd4);
    pulseSrc(1'b0);
    held = foutOut;
    for (int i = 0; i < 3; i++) pulseSrc(1'b1);
    check("R6 serial ignored in normal mode", foutOut, held);
    applyReset(3'b110, 2'd0, 9'd4);
    for (int i = 0; i < 3; i++) pulseSrc(1'b0);
    check("R6 vco ignored in bypass", foutOut, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      pulseSrc(1'b1);
      check("R6 bypass fout from serial", foutOut, 1'(i % 2));
    end
  endtask

  task automatic testMCounter(input bit useSer, input logic [8:0] m);
    applyReset(useSer ? 3'b110 : 3'b011, 2'd1, m);
    for (int i = 1; i <= 3 * int'(m) + 1; i++) begin
      pulseSrc(useSer);
      check(useSer ? "R7 M pulse bypass" : "R7 M pulse vco",
            testOut, 1'((i % int'(m)) == 0));
    end
  endtask

  task automatic testDiv4();
    int rises;
    applyReset(3'b111, 2'd0, 9'd4);
    for (int i = 1; i <= 16; i++) begin
      pulseSrc(1'b0);
      rises = (i + 1) / 2;
      check("R9 fout divided by four", testOut, 1'((rises >> 1) & 1));
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycleCount++;
      if (cycleCount > 100000) begin
        checkCount++;
        failCount++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycleCount);
        finishRun();
      end
    end
  end

  initial begin
    testReset();
    testStatic();
    testRef();
    for (int n = 0; n < 4; n++) testDivider(2'(n));
    testSourceSelect();
    testMCounter(1'b0, 9'd5);
    testMCounter(1'b1, 9'd3);
    testMCounter(1'b0, 9'd2);
    testDiv4();
    finishRun();
  end

endmodule